// File: doc/BRIEF.md
# Branch Condition and Delay-Slot Unit

This unit sits beside the execute stage of a small 32-bit RISC core whose branches carry one mandatory delay slot. Each cycle in which the core executes an instruction, it raises `insn_vld`. When that instruction is a branch, the core also raises `br_req` and presents a 5-bit condition code, the current zero, negative and carry flags, the branch's own address, and either a 5-bit signed word offset (relative form) or a register operand (absolute form).

The unit judges the condition and forms the destination. It then counts off the single instruction that must still execute before fetch turns around. One cycle after that delay-slot instruction retires, it pulses `redirect` with the destination on `redirect_addr`. A branch that fails its condition raises nothing, and the core just steps its PC forward by one instruction (2 bytes).

A branch found in a delay slot is dropped. The redirect already pending is left as it was.

Top module: `brc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `br_taken`, `in_slot` and `redirect` are 0 and `redirect_addr` is all zeros after that edge.
- R2: Condition bit 0 set makes the branch require Z = 0. Condition bit 1 set makes it require Z = 1.
- R3: Bit 4 of the condition picks a second flag: C when 0, N when 1. Bit 2 set requires that flag to be 0, and bit 3 set requires it to be 1. The flag that is not picked has no effect.
- R4: With none of condition bits 0..3 set the branch is always taken. Otherwise it is taken only if every enabled test holds, so a code with bits 0 and 1 both set is never taken.
- R5: In relative form (`br_abs` = 0), the destination is `br_pc` + 2 + 2 × `rel_ofs`. The offset is read as two's complement with bit 4 as sign, and the sum wraps modulo 2^32.
- R6: In absolute form (`br_abs` = 1), the destination is `reg_val` with bits 31..24 forced to 0 and bit 0 forced to 0.
- R7: A branch is evaluated only in a cycle with `insn_vld` = 1. A taken branch makes `br_taken` 1 for exactly the one cycle after that edge. `br_req` with `insn_vld` = 0 has no effect.
- R8: `in_slot` rises the cycle after a taken branch. It stays high through any cycles with `insn_vld` = 0 and falls after the edge at which the next valid instruction (the delay slot) executes.
- R9: `redirect` is 1 for exactly the cycle after the delay-slot instruction executes. During that cycle `redirect_addr` holds the destination of the branch that opened the slot.
- R10: A branch executed while `in_slot` is 1 is ignored. It produces no `br_taken`, does not change `redirect_addr`, and does not queue a second redirect.
- R11: A branch whose condition fails produces no `br_taken`, `in_slot` or `redirect`, and leaves `redirect_addr` unchanged.
- R12: A branch executed in the cycle in which `redirect` is high is evaluated normally and opens a new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_vld | input | 1 | An instruction executes this cycle |
| br_req | input | 1 | The executing instruction is a conditional branch |
| br_abs | input | 1 | 1: absolute form from `reg_val`; 0: relative form |
| cond_code | input | 5 | Condition: [0] Z clear, [1] Z set, [2] flag clear, [3] flag set, [4] flag select (0 = C, 1 = N) |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| br_pc | input | 32 | Byte address of the branch instruction |
| rel_ofs | input | 5 | Signed word offset for the relative form |
| reg_val | input | 32 | Register operand for the absolute form |
| br_taken | output | 1 | One-cycle pulse: the last evaluated branch was taken |
| in_slot | output | 1 | A taken branch is waiting for its delay slot to execute |
| redirect | output | 1 | One-cycle pulse: load `redirect_addr` into the PC |
| redirect_addr | output | 32 | Destination of the pending or just-redirected branch |

## Verification
The bench builds the unit with its defaults: 32-bit words, 24 address bits, 2-byte instructions and a 5-bit offset. With these values, register operands carrying ones above bit 23 and in bit 0 expose the absolute-form mask. The offsets −16 and +15 reach both ends of the relative range, and a branch at address 0 with a negative offset exposes the wrap. Bubbles inside a slot, branches nested in slots and back-to-back branches across a redirect exercise the sequencing.

// File: rtl/brc_pkg.sv
// Shared field layout for the branch condition code.
// Assumes a 5-bit code whose bit positions are fixed by the instruction encoding.
package brc_pkg;

    localparam int COND_W = 5;

    // Packed layout: first member is bit 4, last member is bit 0.
    typedef struct packed {
        logic sel_n;        // [4] 0: test C, 1: test N
        logic need_f_set;   // [3] selected flag must be 1
        logic need_f_clr;   // [2] selected flag must be 0
        logic need_z_set;   // [1] Z must be 1
        logic need_z_clr;   // [0] Z must be 0
    } cond_t;

endpackage

// File: rtl/brc_cond_eval.sv
// Decides whether a branch condition holds for the given flags.
// Purely combinational. Each enabled test is a requirement, and the result
// is their AND, so a code that enables no test always passes.
module brc_cond_eval
    import brc_pkg::*;
(
    input  cond_t cc,
    input  logic  flag_z,
    input  logic  flag_n,
    input  logic  flag_c,
    output logic  hit
);

    logic sel_flag;
    logic z_ok;
    logic f_ok;

    // Pick the second flag under test.
    assign sel_flag = cc.sel_n ? flag_n : flag_c;

    // Each side passes unless an enabled test disagrees with the flag.
    assign z_ok = !(cc.need_z_clr && flag_z) && !(cc.need_z_set && !flag_z);
    assign f_ok = !(cc.need_f_clr && sel_flag) && !(cc.need_f_set && !sel_flag);

    assign hit = z_ok && f_ok;

    // Guard the contradictory Z code and the unconditional code.
    always_comb begin
        if (cc.need_z_clr && cc.need_z_set) begin
            AST_Z_CONFLICT_NEVER: assert (!hit); // R4
        end
        if (!cc.need_z_clr && !cc.need_z_set && !cc.need_f_clr && !cc.need_f_set) begin
            AST_NO_TEST_ALWAYS: assert (hit); // R4
        end
    end

endmodule

// File: rtl/brc_target_calc.sv
// Forms the branch destination for both address forms.
// Relative: pc + INSN_BYTES + offset * INSN_BYTES, with a signed offset.
// Absolute: the register operand confined to ADDR_W bits and made even.
// Assumes OFS_W < XLEN and ADDR_W <= XLEN.
module brc_target_calc #(
    parameter int XLEN       = 32,
    parameter int ADDR_W     = 24,
    parameter int OFS_W      = 5,
    parameter int INSN_BYTES = 2
) (
    input  logic             abs_sel,
    input  logic [XLEN-1:0]  pc,
    input  logic [OFS_W-1:0] ofs,
    input  logic [XLEN-1:0]  reg_val,
    output logic [XLEN-1:0]  target
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] ofs_sx;
    logic [XLEN-1:0] abs_mask;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;

    // Sign-extend the word offset, then scale it to bytes.
    assign ofs_sx  = {{(XLEN-OFS_W){ofs[OFS_W-1]}}, ofs} * STEP;
    assign rel_tgt = pc + STEP + ofs_sx;

    // Build the absolute-form mask; the variant depends on whether any upper bits exist.
    generate
        if (ADDR_W < XLEN) begin : g_narrow
            assign abs_mask = {{(XLEN-ADDR_W){1'b0}}, {(ADDR_W-1){1'b1}}, 1'b0};
        end else begin : g_full
            assign abs_mask = {{(XLEN-1){1'b1}}, 1'b0};
        end
    endgenerate

    assign abs_tgt = reg_val & abs_mask;

    // Select the form requested by the instruction.
    assign target = abs_sel ? abs_tgt : rel_tgt;

endmodule

// File: rtl/brc_slot_fsm.sv
// Sequences a taken branch through its single delay slot.
// Assumes insn_vld marks each executed instruction. A branch is only judged
// outside a slot; the first valid instruction after a taken branch closes
// the slot, and the redirect pulses on the following cycle.
module brc_slot_fsm #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_vld,
    input  logic            br_req,
    input  logic            hit,
    input  logic [XLEN-1:0] target,
    output logic            taken_q,
    output logic            slot_q,
    output logic            redir_q,
    output logic [XLEN-1:0] addr_q
);

    logic judge;
    logic take;
    logic slot_done;

    // A branch counts only when executed outside a pending slot.
    assign judge     = insn_vld && br_req && !slot_q;
    assign take      = judge && hit;
    assign slot_done = slot_q && insn_vld;

    // Register the decision, the slot state, the redirect pulse and the destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            slot_q  <= 1'b0;
            redir_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            taken_q <= take;
            redir_q <= slot_done;
            if (take) begin
                slot_q <= 1'b1;
                addr_q <= target;
            end else if (slot_done) begin
                slot_q <= 1'b0;
            end
        end
    end

    AST_TAKEN_OPENS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |-> slot_q); // R8

    AST_SLOT_WAITS_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q && !insn_vld |=> slot_q && $stable(addr_q)); // R8

    AST_REDIR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        redir_q |=> !redir_q); // R9

    AST_REDIR_AFTER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        redir_q |-> !slot_q && $past(slot_q)); // R9

    AST_NESTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q && insn_vld && br_req |=> !taken_q && $stable(addr_q)); // R10

endmodule

// File: rtl/brc_unit.sv
// Top of the branch condition and delay-slot unit.
// Combines condition evaluation, destination forming and delay-slot
// sequencing; every output is registered. Fetch, decode and flag
// generation live elsewhere in the core.
module brc_unit #(
    parameter int XLEN       = 32,
    parameter int ADDR_W     = 24,
    parameter int OFS_W      = 5,
    parameter int INSN_BYTES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        insn_vld,
    input  logic                        br_req,
    input  logic                        br_abs,
    input  logic [brc_pkg::COND_W-1:0]  cond_code,
    input  logic                        flag_z,
    input  logic                        flag_n,
    input  logic                        flag_c,
    input  logic [XLEN-1:0]             br_pc,
    input  logic [OFS_W-1:0]            rel_ofs,
    input  logic [XLEN-1:0]             reg_val,
    output logic                        br_taken,
    output logic                        in_slot,
    output logic                        redirect,
    output logic [XLEN-1:0]             redirect_addr
);

    brc_pkg::cond_t  cc;
    logic            hit;
    logic [XLEN-1:0] target;

    // View the raw code through the field layout.
    assign cc = cond_code;

    brc_cond_eval u_cond (
        .cc     (cc),
        .flag_z (flag_z),
        .flag_n (flag_n),
        .flag_c (flag_c),
        .hit    (hit)
    );

    brc_target_calc #(
        .XLEN       (XLEN),
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_tgt (
        .abs_sel (br_abs),
        .pc      (br_pc),
        .ofs     (rel_ofs),
        .reg_val (reg_val),
        .target  (target)
    );

    brc_slot_fsm #(
        .XLEN (XLEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .insn_vld (insn_vld),
        .br_req   (br_req),
        .hit      (hit),
        .target   (target),
        .taken_q  (br_taken),
        .slot_q   (in_slot),
        .redir_q  (redirect),
        .addr_q   (redirect_addr)
    );

    AST_VLD_LOW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |=> !br_taken); // R7

    AST_FAIL_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_slot && !br_taken |-> !redirect || $past(in_slot)); // R11

endmodule

// File: tb/brc_unit_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver task models each cycle from the requirements
// and queues the expected outputs; the monitor compares after each edge.
module brc_unit_tb_top;

    localparam real HALF = 2.5;

    typedef struct packed {
        logic        taken;
        logic        slot;
        logic        redir;
        logic [31:0] addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_vld = 1'b0;
    logic        br_req = 1'b0;
    logic        br_abs = 1'b0;
    logic [4:0]  cond_code = '0;
    logic        flag_z = 1'b0;
    logic        flag_n = 1'b0;
    logic        flag_c = 1'b0;
    logic [31:0] br_pc = '0;
    logic [4:0]  rel_ofs = '0;
    logic [31:0] reg_val = '0;
    logic        br_taken;
    logic        in_slot;
    logic        redirect;
    logic [31:0] redirect_addr;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic        m_slot = 1'b0;
    logic [31:0] m_tgt = '0;

    always #(HALF) clk = ~clk;

    brc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .br_req(br_req),
        .br_abs(br_abs), .cond_code(cond_code), .flag_z(flag_z),
        .flag_n(flag_n), .flag_c(flag_c), .br_pc(br_pc), .rel_ofs(rel_ofs),
        .reg_val(reg_val), .br_taken(br_taken), .in_slot(in_slot),
        .redirect(redirect), .redirect_addr(redirect_addr)
    );

    // Condition rules as written in R2..R4.
    function automatic bit cond_ok(input logic [4:0] cc, input bit z, input bit n, input bit c);
        bit f;
        bit ok;
        ok = 1'b1;
        f  = cc[4] ? n : c;
        if (cc[0] && z)  ok = 1'b0;
        if (cc[1] && !z) ok = 1'b0;
        if (cc[2] && f)  ok = 1'b0;
        if (cc[3] && !f) ok = 1'b0;
        return ok;
    endfunction

    // Destination rules as written in R5 and R6.
    function automatic logic [31:0] dest(input bit ab, input logic [31:0] pc,
                                         input logic [4:0] ofs, input logic [31:0] rv);
        int o;
        if (ab) return rv & 32'h00FF_FFFE;
        o = ofs[4] ? int'(ofs) - 32 : int'(ofs);
        return pc + 32'd2 + 32'(o * 2);
    endfunction

    // Drive one cycle of stimulus and queue what the outputs must be after the edge.
    task automatic step(input bit vld, input bit req, input bit ab, input logic [4:0] cc,
                        input bit z, input bit n, input bit c, input logic [31:0] pc,
                        input logic [4:0] ofs, input logic [31:0] rv, input string tag);
        exp_t e;
        bit   tk;
        bit   rd;
        @(negedge clk);
        insn_vld = vld; br_req = req; br_abs = ab; cond_code = cc;
        flag_z = z; flag_n = n; flag_c = c; br_pc = pc; rel_ofs = ofs; reg_val = rv;
        tk = vld && req && !m_slot && cond_ok(cc, z, n, c);
        rd = m_slot && vld;
        if (tk) begin
            m_slot = 1'b1;
            m_tgt  = dest(ab, pc, ofs, rv);
        end else if (rd) begin
            m_slot = 1'b0;
        end
        e.taken = tk; e.slot = m_slot; e.redir = rd; e.addr = m_tgt;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic op(input string tag);
        step(1, 0, 0, 5'd0, 0, 0, 0, 32'h0, 5'd0, 32'h0, tag);
    endtask

    task automatic bubble(input string tag);
        step(0, 0, 0, 5'd0, 0, 0, 0, 32'h0, 5'd0, 32'h0, tag);
    endtask

    // Monitor: after each edge, compare the outputs against the oldest expectation.
    always @(posedge clk) begin
        exp_t  e;
        string t;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (br_taken !== e.taken || in_slot !== e.slot || redirect !== e.redir ||
                redirect_addr !== e.addr) begin
                n_fail++;
                $display("FAIL %s: actual taken=%0b slot=%0b redir=%0b addr=%h expected taken=%0b slot=%0b redir=%0b addr=%h",
                         t, br_taken, in_slot, redirect, redirect_addr,
                         e.taken, e.slot, e.redir, e.addr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_run++;
        if (br_taken !== 1'b0 || in_slot !== 1'b0 || redirect !== 1'b0 || redirect_addr !== 32'h0) begin
            n_fail++;
            $display("FAIL R1 reset: actual taken=%0b slot=%0b redir=%0b addr=%h expected 0 0 0 00000000",
                     br_taken, in_slot, redirect, redirect_addr);
        end
        rst_n = 1'b1;

        // R4 / R5: unconditional, positive offset; then the delay slot and redirect (R8, R9).
        step(1, 1, 0, 5'b00000, 1, 1, 1, 32'h100, 5'd3, 32'h0, "R4 always taken, R5 +3");
        op("R8 delay slot executes");
        op("R9 redirect pulse ends");
        // R2: Z clear / Z set tests.
        step(1, 1, 0, 5'b00001, 1, 0, 0, 32'h200, 5'd1, 32'h0, "R2 need Z clear, Z=1");
        step(1, 1, 0, 5'b00001, 0, 0, 0, 32'h200, 5'd1, 32'h0, "R2 need Z clear, Z=0");
        op("R8 slot");
        step(1, 1, 0, 5'b00010, 0, 0, 0, 32'h300, 5'd2, 32'h0, "R2 need Z set, Z=0 (R11)");
        step(1, 1, 0, 5'b00010, 1, 0, 0, 32'h300, 5'd2, 32'h0, "R2 need Z set, Z=1");
        op("R8 slot");
        // R3: C and N selection; the unselected flag has no effect.
        step(1, 1, 0, 5'b00100, 0, 0, 1, 32'h400, 5'd0, 32'h0, "R3 need C clear, C=1");
        step(1, 1, 0, 5'b00100, 0, 1, 0, 32'h400, 5'd0, 32'h0, "R3 need C clear, C=0 N=1");
        op("R8 slot");
        step(1, 1, 0, 5'b11000, 0, 0, 1, 32'h500, 5'd4, 32'h0, "R3 need N set, N=0 C=1");
        step(1, 1, 0, 5'b11000, 0, 1, 0, 32'h500, 5'd4, 32'h0, "R3 need N set, N=1");
        op("R8 slot");
        // R4: contradictory code never taken; combined tests AND together.
        step(1, 1, 0, 5'b00011, 1, 0, 0, 32'h600, 5'd1, 32'h0, "R4 Z clear and set, Z=1");
        step(1, 1, 0, 5'b00011, 0, 0, 0, 32'h600, 5'd1, 32'h0, "R4 Z clear and set, Z=0");
        step(1, 1, 0, 5'b01010, 1, 0, 0, 32'h600, 5'd1, 32'h0, "R4 Z set and C set, C=0");
        step(1, 1, 0, 5'b01010, 1, 0, 1, 32'h600, 5'd1, 32'h0, "R4 Z set and C set, both");
        op("R8 slot");
        // R5: offset extremes and wrap.
        step(1, 1, 0, 5'b00000, 0, 0, 0, 32'h200, 5'b10000, 32'h0, "R5 offset -16");
        op("R8 slot");
        step(1, 1, 0, 5'b00000, 0, 0, 0, 32'h0, 5'b10000, 32'h0, "R5 wrap below zero");
        op("R8 slot");
        step(1, 1, 0, 5'b00000, 0, 0, 0, 32'h1000, 5'b01111, 32'h0, "R5 offset +15");
        op("R8 slot");
        // R6: absolute form masking.
        step(1, 1, 1, 5'b00000, 0, 0, 0, 32'h1000, 5'd0, 32'hABCD_1235, "R6 mask high and bit 0");
        op("R8 slot");
        step(1, 1, 1, 5'b00000, 0, 0, 0, 32'h1000, 5'd0, 32'hFFFF_FFFF, "R6 all ones");
        // R8: bubbles inside the slot.
        bubble("R8 bubble keeps slot");
        bubble("R8 second bubble");
        op("R8 slot retires after bubbles");
        op("R9 pulse ends");
        // R7: branch without insn_vld ignored.
        step(0, 1, 0, 5'b00000, 0, 0, 0, 32'h700, 5'd2, 32'h0, "R7 insn_vld low ignored");
        bubble("R7 still idle");
        // R10: taken-looking branch in the slot is ignored.
        step(1, 1, 0, 5'b00000, 0, 0, 0, 32'h800, 5'd5, 32'h0, "R10 outer branch taken");
        step(1, 1, 1, 5'b00000, 0, 0, 0, 32'h802, 5'd0, 32'h0012_3456, "R10 branch in slot ignored");
        op("R10 no second redirect");
        op("R10 still quiet");
        // R12: branch during the redirect cycle opens a new slot.
        step(1, 1, 0, 5'b00000, 0, 0, 0, 32'h900, 5'd1, 32'h0, "R12 first branch");
        op("R12 slot");
        step(1, 1, 0, 5'b00000, 0, 0, 0, 32'hA00, 5'd2, 32'h0, "R12 branch during redirect");
        op("R12 second slot");
        op("R12 second redirect ends");
        // R11: failing branch leaves address and sequencing untouched.
        step(1, 1, 0, 5'b00110, 0, 0, 1, 32'hB00, 5'd7, 32'h0, "R11 fail keeps addr");
        bubble("R11 no late redirect");
        bubble("idle");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule